// File: doc/BRIEF.md
# Masked Scan Response Evaluator

This block checks scan-out data on the device itself, so the tester does not have to. Each clock, every one of `N_CHAINS` parallel scan chains delivers one produced response bit. A decompressor delivers the matching expected bit and a care bit alongside it. A chain whose care bit is low takes no part in the check. This lets unknown or unspecified response positions be filled with any value without causing a false failure. The per-chain mismatch bits are combined into a single pass/fail signature in the same cycle. That signature lets the tester stop a failing device at clock-cycle granularity.

The first failure sets a sticky abort request and records the index of the failing compare cycle. It also freezes a scannable register that holds the per-chain mismatch bits of that cycle. In shift mode, this register becomes a serial path from `scan_in_i` to `scan_out_o`, so the failing chains can be read out for diagnosis. The logic is independent of the test content: there is one mux, one XOR and one flip-flop per chain, and the OR chain has `N_CHAINS-1` gates.

Top module: `masked_resp_eval`

## Requirements
- R1: When `care_i[i]` is 0, chain i contributes nothing to the signature, and its captured result bit is 0, whatever `expected_i[i]` and `produced_i[i]` are.
- R2: When `care_i[i]` is 1, chain i's result bit is 1 exactly when `produced_i[i]` differs from `expected_i[i]`.
- R3: `sig_o` is the OR of all chain result bits in the same cycle as the inputs, while `valid_i` is 1 and `shift_en_i` is 0. In any other cycle it is 0.
- R4: `abort_o` rises on the clock edge that ends the first cycle with `sig_o` = 1. It then stays 1 until reset, or until a cycle with `clr_fail_i` = 1, which clears it at that edge. The clear has priority over a failure in the same cycle.
- R5: A compare cycle is a cycle with `valid_i` = 1 and `shift_en_i` = 0. Compare cycles are counted from 0 after reset, and the count continues through aborts and clears. On the edge that sets `abort_o`, `fail_cycle_o` takes the index of the failing compare cycle. It holds that value while `abort_o` stays high, and the clear sets it to 0.
- R6: The result register loads all chain result bits at the end of each compare cycle in which `abort_o` is 0. While `abort_o` is 1 it keeps the bits of the failing cycle.
- R7: While `shift_en_i` is 1, each clock moves the result register one place toward chain 0, and `scan_in_i` enters at chain `N_CHAINS-1`. `scan_out_o` always shows the bit held for chain 0, so bits leave in the order chain 0 first. Shift mode overrides compare.
- R8: A cycle with `valid_i` = 0 and `shift_en_i` = 0 changes neither the result register nor the compare-cycle count.
- R9: A synchronous active-high `rst` clears the result register, the abort flag, the compare-cycle count and `fail_cycle_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Response/expected/care bits are valid this cycle |
| shift_en_i | input | 1 | Serial shift mode for the result register |
| clr_fail_i | input | 1 | Clears the abort flag and the recorded failing index |
| produced_i | input | N_CHAINS | Produced scan-out bit per chain |
| expected_i | input | N_CHAINS | Decompressed expected bit per chain |
| care_i | input | N_CHAINS | Care mask, 1 = compare this chain |
| scan_in_i | input | 1 | Serial input into the result register |
| scan_out_o | output | 1 | Serial output, the bit held for chain 0 |
| sig_o | output | 1 | Per-cycle pass (0) / fail (1) signature |
| abort_o | output | 1 | Sticky abort request |
| fail_cycle_o | output | CNT_W | Index of the first failing compare cycle |

## Verification
The signature is combinational, so a wrong mask or compare shows up at `sig_o` in the very cycle the bits are applied. A corrupted abort flag or index appears on the next edge, as a missing or spurious `abort_o` or a wrong `fail_cycle_o`. A wrong capture or freeze only becomes visible once the register is shifted out. For that reason the bench shifts all `N_CHAINS` bits out after each failure, and after cycles in which `valid_i` is low. It then compares every serial bit against its model one clock at a time.

// File: rtl/resp_eval_pkg.sv
package resp_eval_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE    = 2'd0,
    MODE_COMPARE = 2'd1,
    MODE_SHIFT   = 2'd2
  } eval_mode_e;

  function automatic eval_mode_e decode_mode(input logic valid, input logic shift_en);
    if (shift_en)   return MODE_SHIFT;
    else if (valid) return MODE_COMPARE;
    else            return MODE_IDLE;
  endfunction
endpackage

// File: rtl/chain_compare.sv
module chain_compare #(
  parameter int N_CHAINS = 8
) (
  input  logic [N_CHAINS-1:0] produced_i,
  input  logic [N_CHAINS-1:0] expected_i,
  input  logic [N_CHAINS-1:0] care_i,
  output logic [N_CHAINS-1:0] mismatch_o
);
  // one XOR and one care-selected mux per chain
  for (genvar i = 0; i < N_CHAINS; i++) begin : g_bit
    logic diff;
    assign diff          = produced_i[i] ^ expected_i[i];
    assign mismatch_o[i] = care_i[i] ? diff : 1'b0;
  end
endmodule

// File: rtl/or_chain.sv
module or_chain #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] bits_i,
  output logic             any_o
);
  logic [WIDTH-1:0] acc;
  assign acc[0] = bits_i[0];
  // WIDTH-1 two-input ORs
  for (genvar i = 1; i < WIDTH; i++) begin : g_or
    assign acc[i] = acc[i-1] | bits_i[i];
  end
  assign any_o = acc[WIDTH-1];
endmodule

// File: rtl/result_scan_reg.sv
module result_scan_reg
  import resp_eval_pkg::*;
#(
  parameter int N_CHAINS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  eval_mode_e          mode_i,
  input  logic                hold_i,
  input  logic [N_CHAINS-1:0] capture_i,
  input  logic                scan_in_i,
  output logic [N_CHAINS-1:0] q_o,
  output logic                scan_out_o
);
  logic [N_CHAINS-1:0] q;

  for (genvar i = 0; i < N_CHAINS; i++) begin : g_sff
    logic shift_src;
    if (i == N_CHAINS - 1) begin : g_top
      assign shift_src = scan_in_i;
    end else begin : g_mid
      assign shift_src = q[i+1];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        q[i] <= 1'b0;
      end else if (mode_i == MODE_SHIFT) begin
        q[i] <= shift_src;
      end else if (mode_i == MODE_COMPARE && !hold_i) begin
        q[i] <= capture_i[i];
      end
    end
  end

  assign q_o        = q;
  assign scan_out_o = q[0];
endmodule

// File: rtl/fail_tracker.sv
module fail_tracker
  import resp_eval_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  eval_mode_e       mode_i,
  input  logic             sig_i,
  input  logic             clr_i,
  output logic             abort_o,
  output logic [CNT_W-1:0] fail_cycle_o
);
  logic             flag_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] idx_q;
  logic             first_fail;

  assign first_fail = sig_i && !flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (mode_i == MODE_COMPARE) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      idx_q  <= '0;
    end else if (clr_i) begin
      flag_q <= 1'b0;
      idx_q  <= '0;
    end else if (first_fail) begin
      flag_q <= 1'b1;
      idx_q  <= cnt_q;
    end
  end

  assign abort_o      = flag_q;
  assign fail_cycle_o = idx_q;
endmodule

// File: rtl/masked_resp_eval.sv
module masked_resp_eval
  import resp_eval_pkg::*;
#(
  parameter int N_CHAINS = 8,
  parameter int CNT_W    = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                valid_i,
  input  logic                shift_en_i,
  input  logic                clr_fail_i,
  input  logic [N_CHAINS-1:0] produced_i,
  input  logic [N_CHAINS-1:0] expected_i,
  input  logic [N_CHAINS-1:0] care_i,
  input  logic                scan_in_i,
  output logic                scan_out_o,
  output logic                sig_o,
  output logic                abort_o,
  output logic [CNT_W-1:0]    fail_cycle_o
);
  eval_mode_e          mode;
  logic [N_CHAINS-1:0] mismatch;
  logic                any_mismatch;
  logic [N_CHAINS-1:0] res_q;

  assign mode = decode_mode(valid_i, shift_en_i);

  chain_compare #(.N_CHAINS(N_CHAINS)) u_cmp (
    .produced_i (produced_i),
    .expected_i (expected_i),
    .care_i     (care_i),
    .mismatch_o (mismatch)
  );

  or_chain #(.WIDTH(N_CHAINS)) u_or (
    .bits_i (mismatch),
    .any_o  (any_mismatch)
  );

  assign sig_o = (mode == MODE_COMPARE) && any_mismatch;

  result_scan_reg #(.N_CHAINS(N_CHAINS)) u_res (
    .clk        (clk),
    .rst        (rst),
    .mode_i     (mode),
    .hold_i     (abort_o),
    .capture_i  (mismatch),
    .scan_in_i  (scan_in_i),
    .q_o        (res_q),
    .scan_out_o (scan_out_o)
  );

  fail_tracker #(.CNT_W(CNT_W)) u_fail (
    .clk          (clk),
    .rst          (rst),
    .mode_i       (mode),
    .sig_i        (sig_o),
    .clr_i        (clr_fail_i),
    .abort_o      (abort_o),
    .fail_cycle_o (fail_cycle_o)
  );
endmodule

// File: rtl/resp_eval_checker.sv
module resp_eval_checker #(
  parameter int N_CHAINS = 8,
  parameter int CNT_W    = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                shift_en_i,
  input logic                clr_fail_i,
  input logic [N_CHAINS-1:0] care_i,
  input logic                scan_in_i,
  input logic                sig_o,
  input logic                abort_o,
  input logic [CNT_W-1:0]    fail_cycle_o,
  input logic [N_CHAINS-1:0] res_q
);
  p_masked_pass_r1: assert property (@(posedge clk) disable iff (rst)
    (care_i == '0) |-> !sig_o);

  p_no_sig_in_shift_r3: assert property (@(posedge clk) disable iff (rst)
    shift_en_i |-> !sig_o);

  p_abort_sets_r4: assert property (@(posedge clk) disable iff (rst)
    (sig_o && !clr_fail_i) |=> abort_o);

  p_abort_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (abort_o && !clr_fail_i) |=> abort_o);

  p_abort_clear_r4: assert property (@(posedge clk) disable iff (rst)
    clr_fail_i |=> !abort_o);

  p_index_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (abort_o && !clr_fail_i) |=> $stable(fail_cycle_o));

  p_freeze_r6: assert property (@(posedge clk) disable iff (rst)
    (abort_o && !shift_en_i) |=> $stable(res_q));

  p_shift_entry_r7: assert property (@(posedge clk) disable iff (rst)
    shift_en_i |=> (res_q[N_CHAINS-1] == $past(scan_in_i)));

  p_reset_clears_r9: assert property (@(posedge clk)
    rst |=> (!abort_o && fail_cycle_o == '0 && res_q == '0));
endmodule

bind masked_resp_eval resp_eval_checker #(.N_CHAINS(N_CHAINS), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .shift_en_i   (shift_en_i),
  .clr_fail_i   (clr_fail_i),
  .care_i       (care_i),
  .scan_in_i    (scan_in_i),
  .sig_o        (sig_o),
  .abort_o      (abort_o),
  .fail_cycle_o (fail_cycle_o),
  .res_q        (res_q)
);

// File: tb/tb_masked_resp_eval.sv
`timescale 1ns/1ps
module tb_masked_resp_eval;
  localparam int N     = 8;
  localparam int CW    = 16;
  localparam int WDOG  = 5000;

  logic clk = 1'b0;
  logic rst, valid, shen, clr, sin;
  logic [N-1:0] prod, expv, care;
  logic sout, sig, abrt;
  logic [CW-1:0] fcyc;

  always #10 clk = ~clk;

  masked_resp_eval #(.N_CHAINS(N), .CNT_W(CW)) dut (
    .clk(clk), .rst(rst), .valid_i(valid), .shift_en_i(shen), .clr_fail_i(clr),
    .produced_i(prod), .expected_i(expv), .care_i(care), .scan_in_i(sin),
    .scan_out_o(sout), .sig_o(sig), .abort_o(abrt), .fail_cycle_o(fcyc)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // behavioural model state
  bit   m_res[$];
  bit   m_flag;
  int   m_cnt;
  int   m_fidx;

  task automatic check(string tag, int act, int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp_v, $time);
    end
  endtask

  task automatic model_reset();
    m_res.delete();
    for (int i = 0; i < N; i++) m_res.push_back(1'b0);
    m_flag = 0; m_cnt = 0; m_fidx = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; valid = 0; shen = 0; clr = 0; sin = 0; prod = '0; expv = '0; care = '0;
    @(posedge clk);
    model_reset();
    @(negedge clk);
    rst = 0;
    #2;
    check("R9 abort after reset", int'(abrt), 0);
    check("R9 index after reset", int'(fcyc), 0);
    check("R9 scan_out after reset", int'(sout), 0);
  endtask

  // one clock: drive, compare everything against the model, then advance the model
  task automatic cyc(string tag, bit v, bit sh, bit c, logic [N-1:0] p,
                     logic [N-1:0] e, logic [N-1:0] k, bit si);
    bit ms;
    bit any;
    @(negedge clk);
    valid = v; shen = sh; clr = c; prod = p; expv = e; care = k; sin = si;
    #2;
    any = 0;
    for (int i = 0; i < N; i++) if (k[i] && (p[i] != e[i])) any = 1;
    ms = v && !sh && any;
    check({tag, " sig (R3)"}, int'(sig), int'(ms));
    check("R4 abort", int'(abrt), int'(m_flag));
    check("R5 fail index", int'(fcyc), m_fidx);
    check("R7 scan_out", int'(sout), int'(m_res[0]));
    @(posedge clk);
    if (sh) begin
      void'(m_res.pop_front());
      m_res.push_back(si);
    end else if (v && !m_flag) begin
      for (int i = 0; i < N; i++) m_res[i] = k[i] && (p[i] != e[i]);
    end
    if (c) begin
      m_flag = 0; m_fidx = 0;
    end else if (ms && !m_flag) begin
      m_flag = 1; m_fidx = m_cnt;
    end
    if (v && !sh) m_cnt++;
  endtask

  task automatic shift_all(string tag);
    for (int i = 0; i < N; i++) cyc(tag, 0, 1, 0, '0, '0, '0, 1'(i & 1));
  endtask

  initial begin
    #(WDOG * 20);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1; valid = 0; shen = 0; clr = 0; sin = 0; prod = '0; expv = '0; care = '0;
    model_reset();
    do_reset();

    // R1: masked-off chains never fail, whatever the data
    for (int j = 0; j < 12; j++)
      cyc("R1 masked", 1, 0, 0, N'(j * 37 + 5), N'(j * 91 + 2), '0, 0);
    // R1 partial mask: differing bits only where care is low
    cyc("R1 partial", 1, 0, 0, 8'hF0, 8'h0F, 8'h00, 0);
    cyc("R1 partial", 1, 0, 0, 8'hAA, 8'hA5, 8'hF0, 0);
    // R2: all cared, equal data passes
    for (int j = 0; j < 6; j++)
      cyc("R2 equal", 1, 0, 0, N'(j * 53), N'(j * 53), '1, 0);
    // R2 worked example on chains 2..0: exp 110, prod 010, care 010 -> pass
    cyc("R2 example", 1, 0, 0, 8'b0000_0010, 8'b0000_0110, 8'b0000_0010, 0);
    // R8: idle cycles with garbage data change nothing
    cyc("R8 idle", 0, 0, 0, 8'hFF, 8'h00, 8'hFF, 0);
    cyc("R8 idle", 0, 0, 0, 8'h0F, 8'hF0, 8'hFF, 0);
    // R8: shift out the last captured (all-zero) result
    shift_all("R8 readout");

    // R2/R3/R4/R5: fail on chains 1 and 6
    cyc("R2 fail", 1, 0, 0, 8'b0100_0010, 8'b0000_0000, 8'b1100_0011, 0);
    // R6: later mismatches must not overwrite the frozen result
    cyc("R6 frozen", 1, 0, 0, 8'hFF, 8'h00, 8'hFF, 0);
    cyc("R6 frozen", 1, 0, 0, 8'h01, 8'h00, 8'h01, 0);
    // R6/R7: read out the failing chains, chain 0 first
    shift_all("R7 shift");
    // R3: shift mode with mismatching data gives no signature
    cyc("R3 shift", 1, 1, 0, 8'hFF, 8'h00, 8'hFF, 1);

    // R4: clear, then a new first failure at a later index
    cyc("R4 clear", 1, 0, 1, 8'h00, 8'h00, 8'hFF, 0);
    cyc("R4 pass", 1, 0, 0, 8'h3C, 8'h3C, 8'hFF, 0);
    cyc("R5 fail", 1, 0, 0, 8'h80, 8'h00, 8'h80, 0);
    cyc("R4 held", 1, 0, 0, 8'h00, 8'h00, 8'hFF, 0);
    // R4: clear wins over a failure in the same cycle
    cyc("R4 clear-prio", 1, 0, 1, 8'h01, 8'h00, 8'h01, 0);
    cyc("R4 after", 0, 0, 0, 8'h00, 8'h00, 8'h00, 0);
    shift_all("R6 readout");

    // R9: reset mid-run clears the abort and the index
    cyc("R9 pre", 1, 0, 0, 8'h10, 8'h00, 8'h10, 0);
    cyc("R9 pre", 1, 0, 0, 8'h00, 8'h00, 8'h00, 0);
    do_reset();
    cyc("R9 post", 1, 0, 0, 8'h00, 8'h00, 8'hFF, 0);
    cyc("R9 post", 1, 0, 0, 8'h02, 8'h00, 8'h02, 0);
    cyc("R9 post", 0, 0, 0, 8'h00, 8'h00, 8'h00, 0);
    shift_all("R7 final");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule